// File: doc/BRIEF.md
# Task-to-Event Signaling Hub

This peripheral connects firmware with a shared hardware event fabric. It holds sixteen lanes. Each lane pairs one task with one event. A task can be fired in two ways: a processor write to the task's trigger word, or a pulse on a chosen line of a 256-line channel input vector. Firing a task raises the lane's event flag. Task n only ever raises flag n.

Each raised event can do two further things, each under its own control:

- emit a one-cycle pulse on a chosen line of a 256-line channel output vector;
- request an interrupt, if that lane is unmasked.

One use is to hand work from a high-priority context to a lower-priority one. Another is to fan one hardware event out to several consumers.

Software reaches the block through a simple 32-bit register port (address, write strobe, write data, combinational read data). Each lane has four words at fixed strides: trigger, subscription, flag and publication. A single interrupt mask can be reached at three addresses: direct, set-only and clear-only.

Top module: `sig_event_hub`

## Requirements
- R1: After reset all subscription, publication, flag and mask registers are zero. The interrupt line is low, the channel output is all zero, and every mapped address reads 0.
- R2: Writing a word with bit 0 = 1 to address 0x000 + 4·n raises flag n and no other flag. Writing bit 0 = 0 there changes nothing. These addresses always read 0.
- R3: The word at 0x080 + 4·n holds a channel number in bits 7:0 and an enable in bit 31. It reads back as written, with all other bits 0. While the enable is 1, every clock edge at which the selected channel input bit is 1 raises flag n. While the enable is 0, the channel input has no effect on lane n.
- R4: The word at 0x100 + 4·n returns flag n in bit 0. A write stores bit 0 into the flag, so writing 0 clears it. Writing 1 this way raises the flag but emits no channel pulse.
- R5: The word at 0x180 + 4·n holds a channel number in bits 7:0 and an enable in bit 31, and reads back as written. When a task fires while the enable is 1, the selected channel output bit is 1 for exactly the one cycle after the firing clock edge. When the enable is 0, the output stays 0.
- R6: Pulses from several lanes aimed at the same channel are ORed into one output bit. A software trigger and a channel trigger for the same lane at the same edge yield a single one-cycle pulse.
- R7: The mask at 0x300 is read/write, with bit i for lane i. Writing 1s to 0x304 sets those mask bits. Writing 1s to 0x308 clears them. Zero bits written to either address leave the mask unchanged. All three addresses read the current mask.
- R8: The interrupt output is 1 exactly when some lane has both its flag and its mask bit at 1. It stays 1 until software clears the flag or the mask bit.
- R9: If a task fires at the same edge as a software write of 0 to that lane's flag, the flag ends at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 12 | Register byte address |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| chan_in | input | 256 | Channel input lines, sampled at each edge |
| chan_out | output | 256 | Channel output lines, one-cycle pulses |
| irq | output | 1 | Level interrupt request |

## Verification
The bench checks that a trigger on one lane raises no neighbouring flag. A decoder that is off by one stride would set the wrong event. It checks that a disabled subscription or publication is inert, and that a flag written to 1 by software emits no pulse; a design that gated on the flag rather than on the trigger would leak pulses. It checks that coinciding software and channel triggers give one pulse, not a two-cycle one, and that two lanes sharing an output channel merge. It checks that a flag clear colliding with a trigger leaves the flag set; a design that ordered the two the other way would lose the event. It also checks that set-only and clear-only mask writes ignore zero bits; a design that wrote them through directly would wipe the mask.

// File: rtl/sig_event_pkg.sv
// Package: shared sizes and address map of the signaling hub.
// Assumes N_EVT <= 32, so a lane index fits the 5-bit word field, and
// N_CHAN is a power of two.
package sig_event_pkg;
    localparam int N_EVT  = 16;
    localparam int N_CHAN = 256;
    localparam int CHAN_W = $clog2(N_CHAN);
    localparam int ADDR_W = 12;

    // Lane register groups, decoded from bus_addr[11:7]
    localparam logic [4:0] GRP_TASK = 5'h0;
    localparam logic [4:0] GRP_SUB  = 5'h1;
    localparam logic [4:0] GRP_FLAG = 5'h2;
    localparam logic [4:0] GRP_PUB  = 5'h3;

    // Interrupt mask words, decoded from bus_addr[11:2]
    localparam logic [9:0] WRD_MASK = 10'h0C0;
    localparam logic [9:0] WRD_MSET = 10'h0C1;
    localparam logic [9:0] WRD_MCLR = 10'h0C2;
endpackage

// File: rtl/sig_event_lane.sv
// Module: one task/event lane.
// Holds the lane's subscription and publication settings and its flag.
// Registers a publish pulse together with the channel it targets.
// Assumes write strobes are already decoded for this lane.
module sig_event_lane #(
    parameter int N_CHAN = 256,
    parameter int CHAN_W = $clog2(N_CHAN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_task,
    input  logic              wr_sub,
    input  logic              wr_flag,
    input  logic              wr_pub,
    input  logic              wbit0,
    input  logic              wbit31,
    input  logic [CHAN_W-1:0] widx,
    input  logic [N_CHAN-1:0] chan_in,
    output logic              sub_en,
    output logic [CHAN_W-1:0] sub_idx,
    output logic              pub_en,
    output logic [CHAN_W-1:0] pub_idx,
    output logic              flag,
    output logic              pulse,
    output logic [CHAN_W-1:0] pulse_idx
);
    logic fire;

    // Fire on a software trigger, on a subscribed channel, or on both at once
    always_comb fire = (wr_task && wbit0) || (sub_en && chan_in[sub_idx]);

    // Subscription settings
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sub_en  <= 1'b0;
            sub_idx <= '0;
        end else if (wr_sub) begin
            sub_en  <= wbit31;
            sub_idx <= widx;
        end
    end

    // Publication settings
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pub_en  <= 1'b0;
            pub_idx <= '0;
        end else if (wr_pub) begin
            pub_en  <= wbit31;
            pub_idx <= widx;
        end
    end

    // Event flag: a firing task takes priority over a software write
    always_ff @(posedge clk) begin
        if (!rst_n)       flag <= 1'b0;
        else if (fire)    flag <= 1'b1;
        else if (wr_flag) flag <= wbit0;
    end

    // One-cycle publish pulse, with the channel captured at the firing edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse     <= 1'b0;
            pulse_idx <= '0;
        end else begin
            pulse     <= fire && pub_en;
            pulse_idx <= pub_idx;
        end
    end

    // R2
    task_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_task && wbit0) |=> flag);
    // R3
    sub_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_en && chan_in[sub_idx]) |=> flag);
    // R5
    pulse_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> flag);
    // R4
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_flag && !wbit0 && !fire) |=> !flag);
endmodule

// File: rtl/sig_event_fanout.sv
// Module: merges the publish pulses of all lanes onto the channel output vector.
// Lanes aimed at the same channel are ORed. Assumes pulses come from registers.
module sig_event_fanout #(
    parameter int N_EVT  = 16,
    parameter int N_CHAN = 256,
    parameter int CHAN_W = $clog2(N_CHAN)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [N_EVT-1:0]             pulse,
    input  logic [N_EVT-1:0][CHAN_W-1:0] pulse_idx,
    output logic [N_CHAN-1:0]            chan_out
);
    // Decode each active pulse onto its channel bit
    always_comb begin
        chan_out = '0;
        for (int n = 0; n < N_EVT; n++) begin
            if (pulse[n]) chan_out[pulse_idx[n]] = 1'b1;
        end
    end

    // R6
    out_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|chan_out) |-> (|pulse));
    // R6
    out_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(chan_out) <= $countones(pulse));
endmodule

// File: rtl/sig_event_hub.sv
// Module: top of the signaling hub.
// Decodes the register port, holds the interrupt mask, muxes read data and
// forms the interrupt. Assumes one bus access per cycle, word-aligned
// addresses, N_EVT <= 31 and N_EVT >= CHAN_W.
module sig_event_hub
    import sig_event_pkg::*;
#(
    parameter int LANES = N_EVT,
    parameter int CHANS = N_CHAN,
    localparam int CW   = $clog2(CHANS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [CHANS-1:0]  chan_in,
    output logic [CHANS-1:0]  chan_out,
    output logic              irq
);
    logic [4:0]               grp;
    logic [4:0]               sel;
    logic                     aligned;
    logic [9:0]               word;
    logic [LANES-1:0]         wr_task, wr_sub, wr_flag, wr_pub;
    logic [LANES-1:0]         sub_en, pub_en, flag, pulse;
    logic [LANES-1:0][CW-1:0] sub_idx, pub_idx, pulse_idx;
    logic [LANES-1:0]         mask;
    logic                     unused_wbits;

    assign grp          = bus_addr[11:7];
    assign sel          = bus_addr[6:2];
    assign word         = bus_addr[11:2];
    assign aligned      = (bus_addr[1:0] == 2'b00);
    assign unused_wbits = ^bus_wdata[30:LANES];

    // Per-lane write strobes
    always_comb begin
        for (int n = 0; n < LANES; n++) begin
            wr_task[n] = bus_we && aligned && grp == GRP_TASK && sel == 5'(n);
            wr_sub[n]  = bus_we && aligned && grp == GRP_SUB  && sel == 5'(n);
            wr_flag[n] = bus_we && aligned && grp == GRP_FLAG && sel == 5'(n);
            wr_pub[n]  = bus_we && aligned && grp == GRP_PUB  && sel == 5'(n);
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sig_event_lane #(.N_CHAN(CHANS), .CHAN_W(CW)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_task   (wr_task[g]),
            .wr_sub    (wr_sub[g]),
            .wr_flag   (wr_flag[g]),
            .wr_pub    (wr_pub[g]),
            .wbit0     (bus_wdata[0]),
            .wbit31    (bus_wdata[31]),
            .widx      (bus_wdata[CW-1:0]),
            .chan_in   (chan_in),
            .sub_en    (sub_en[g]),
            .sub_idx   (sub_idx[g]),
            .pub_en    (pub_en[g]),
            .pub_idx   (pub_idx[g]),
            .flag      (flag[g]),
            .pulse     (pulse[g]),
            .pulse_idx (pulse_idx[g])
        );
    end

    sig_event_fanout #(.N_EVT(LANES), .N_CHAN(CHANS), .CHAN_W(CW)) u_fanout (
        .clk       (clk),
        .rst_n     (rst_n),
        .pulse     (pulse),
        .pulse_idx (pulse_idx),
        .chan_out  (chan_out)
    );

    // Interrupt mask: direct write, set-only and clear-only aliases
    always_ff @(posedge clk) begin
        if (!rst_n) mask <= '0;
        else if (bus_we && aligned) begin
            case (word)
                WRD_MASK: mask <= bus_wdata[LANES-1:0];
                WRD_MSET: mask <= mask | bus_wdata[LANES-1:0];
                WRD_MCLR: mask <= mask & ~bus_wdata[LANES-1:0];
                default:  mask <= mask;
            endcase
        end
    end

    // Read data mux
    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            if (word == WRD_MASK || word == WRD_MSET || word == WRD_MCLR)
                bus_rdata[LANES-1:0] = mask;
            for (int n = 0; n < LANES; n++) begin
                if (sel == 5'(n)) begin
                    case (grp)
                        GRP_SUB:  bus_rdata = {sub_en[n], {(31-CW){1'b0}}, sub_idx[n]};
                        GRP_FLAG: bus_rdata = {31'b0, flag[n]};
                        GRP_PUB:  bus_rdata = {pub_en[n], {(31-CW){1'b0}}, pub_idx[n]};
                        default:  ;
                    endcase
                end
            end
        end
    end

    // Level interrupt from unmasked flags
    assign irq = |(flag & mask);

    // R7
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 12'h304) |=>
            ((mask & $past(bus_wdata[LANES-1:0])) == $past(bus_wdata[LANES-1:0])));
    // R7
    mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 12'h308) |=> ((mask & $past(bus_wdata[LANES-1:0])) == '0));
    // R7
    mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && (bus_addr == 12'h304 || bus_addr == 12'h308) && bus_wdata[LANES-1:0] == '0)
            |=> $stable(mask));
    // R8
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|flag));
endmodule

// File: tb/sig_event_hub_bench.sv
module sig_event_hub_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [11:0]  bus_addr = '0;
    logic         bus_we = 1'b0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [255:0] chan_in = '0;
    logic [255:0] chan_out;
    logic         irq;
    int           errors = 0;
    int           checks = 0;
    bit           done = 1'b0;

    always #5 clk = ~clk;

    sig_event_hub u_sig_event_hub (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .chan_in(chan_in),
        .chan_out(chan_out), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    task automatic chan_pulse(input logic [255:0] v);
        @(negedge clk);
        chan_in = v;
        @(negedge clk);
        chan_in = '0;
    endtask

    task automatic t_reset();
        chk("R1 irq", 32'(irq), 0);
        chk("R1 chan_out", 32'($countones(chan_out)), 0);
        rd_chk("R1 mask", 12'h300, 0);
        rd_chk("R1 flag", 12'h100, 0);
        rd_chk("R1 sub", 12'h080, 0);
        rd_chk("R1 pub", 12'h180, 0);
    endtask

    task automatic t_task_sw();
        wr(12'h008, 32'h1);
        rd_chk("R2 flag2", 12'h108, 1);
        rd_chk("R2 flag1", 12'h104, 0);
        rd_chk("R2 flag3", 12'h10C, 0);
        rd_chk("R2 task reads 0", 12'h008, 0);
        wr(12'h014, 32'h0);
        rd_chk("R2 zero write", 12'h114, 0);
    endtask

    task automatic t_flag_rw();
        wr(12'h108, 32'h0);
        rd_chk("R4 cleared", 12'h108, 0);
        wr(12'h18C, 32'h8000_0009);
        wr(12'h10C, 32'h1);
        chk("R4 sw set no pulse", 32'(chan_out[9]), 0);
        rd_chk("R4 sw set", 12'h10C, 1);
        wr(12'h10C, 32'h0);
    endtask

    task automatic t_subscribe();
        wr(12'h084, 32'h8000_0021);
        rd_chk("R3 readback", 12'h084, 32'h8000_0021);
        chan_pulse(256'(1) << 33);
        rd_chk("R3 subscribed fire", 12'h104, 1);
        wr(12'h088, 32'h0000_0028);
        rd_chk("R3 readback off", 12'h088, 32'h0000_0028);
        chan_pulse(256'(1) << 40);
        rd_chk("R3 disabled inert", 12'h108, 0);
    endtask

    task automatic t_publish();
        wr(12'h190, 32'h8000_00C8);
        rd_chk("R5 readback", 12'h190, 32'h8000_00C8);
        wr(12'h010, 32'h1);
        chk("R5 pulse bit", 32'(chan_out[200]), 1);
        chk("R5 pulse alone", 32'($countones(chan_out)), 1);
        @(negedge clk);
        chk("R5 one cycle", 32'($countones(chan_out)), 0);
        wr(12'h198, 32'h0000_0007);
        wr(12'h018, 32'h1);
        chk("R5 disabled no pulse", 32'($countones(chan_out)), 0);
    endtask

    task automatic t_merge();
        wr(12'h09C, 32'h8000_000A);
        wr(12'h0A0, 32'h8000_000B);
        wr(12'h19C, 32'h8000_004D);
        wr(12'h1A0, 32'h8000_004D);
        chan_pulse((256'(1) << 10) | (256'(1) << 11));
        chk("R6 merged bit", 32'(chan_out[77]), 1);
        chk("R6 merged count", 32'($countones(chan_out)), 1);
        wr(12'h0A4, 32'h8000_000C);
        wr(12'h1A4, 32'h8000_005A);
        @(negedge clk);
        chan_in = 256'(1) << 12;
        bus_addr = 12'h024; bus_wdata = 32'h1; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; chan_in = '0;
        chk("R6 dual trigger pulse", 32'(chan_out[90]), 1);
        @(negedge clk);
        chk("R6 dual trigger single", 32'(chan_out[90]), 0);
    endtask

    task automatic t_mask();
        wr(12'h304, 32'h5);
        rd_chk("R7 set", 12'h300, 32'h5);
        wr(12'h304, 32'h2);
        rd_chk("R7 set keeps", 12'h300, 32'h7);
        wr(12'h308, 32'h4);
        rd_chk("R7 clr", 12'h300, 32'h3);
        wr(12'h308, 32'h0);
        rd_chk("R7 clr zero", 12'h300, 32'h3);
        wr(12'h300, 32'h8000);
        rd_chk("R7 set alias read", 12'h304, 32'h8000);
        rd_chk("R7 clr alias read", 12'h308, 32'h8000);
    endtask

    task automatic t_irq();
        for (int n = 0; n < 16; n++) wr(12'(12'h100 + 4 * n), 32'h0);
        wr(12'h300, 32'h1);
        chk("R8 idle", 32'(irq), 0);
        wr(12'h00C, 32'h1);
        chk("R8 masked lane", 32'(irq), 0);
        wr(12'h000, 32'h1);
        chk("R8 raised", 32'(irq), 1);
        repeat (3) @(negedge clk);
        chk("R8 held", 32'(irq), 1);
        wr(12'h100, 32'h0);
        chk("R8 cleared", 32'(irq), 0);
    endtask

    task automatic t_race();
        wr(12'h0A8, 32'h8000_0014);
        @(negedge clk);
        chan_in = 256'(1) << 20;
        bus_addr = 12'h128; bus_wdata = 32'h0; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; chan_in = '0;
        rd_chk("R9 trigger wins", 12'h128, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_task_sw();
        t_flag_rw();
        t_subscribe();
        t_publish();
        t_merge();
        t_mask();
        t_irq();
        t_race();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule